// File: doc/BRIEF.md
# Interrupt Pin Delivery and EOI Engine

This block sits between the interrupt input pins of an I/O interrupt router and the message fabric that reaches the processors. It keeps, for each of 32 pins, a saturating count of outstanding assertions and a 64-bit redirection entry. A delivery attempt happens only when a pin's count leaves zero. The attempt is suppressed when the entry is masked. For a level-triggered entry the attempt sets a per-pin remote-IRR flag, which holds off re-delivery until the processor signals end-of-interrupt for that vector.

Requests arrive as a pin number with an operation code (raise, lower or pulse), as 32-bit half-entry writes, and as EOI vectors. Pins with a delivery waiting hold a pending bit. A fixed lowest-pin-first arbiter drains these bits into a single registered valid/ready message port. Each message carries vector, delivery mode, destination mode, trigger level and destination. A one-cycle trigger-mode recalculation request is raised whenever a write alters an entry in a field other than mask or polarity.

Top module: `ioapic_pin_engine`

## Requirements
- R1: Pin operation codes are 0 none, 1 raise, 2 lower and 3 pulse. Raise adds one to the pin's count, saturating at the maximum, and lower subtracts one. A delivery attempt is made only when raise finds the count at zero. A lower never produces a message.
- R2: A pulse (code 3) behaves as a raise followed at once by a lower. It leaves the count unchanged and makes a delivery attempt only when the count was zero.
- R3: An entry with its mask bit (bit 16) set produces no message from any attempt.
- R4: An attempt on an unmasked entry with trigger bit 15 set (level) sets the pin's remote-IRR flag. Entry writes never change that flag, and bits 12 and 14 of the low word always hold zero.
- R5: Message fields come from the entry as follows: vector from bits 7:0, delivery mode from bits 10:8, logical destination from bit 11, level from bit 15, and destination from bits 63:56.
- R6: An EOI for vector v clears remote-IRR on every pin whose flag is set and whose entry vector equals v. Each such pin with a count above zero is delivered again.
- R7: After a write to an entry, the pin is delivered if the entry is unmasked, its remote-IRR is clear and its count is above zero.
- R8: `tmr_req_o` pulses for one cycle, one cycle after a write whose change touches any bit other than mask (16) and polarity (13). It stays low otherwise.
- R9: Pin requests and writes naming a pin at or above 32 have no effect.
- R10: A lower on a zero count leaves the count at zero and sets `cnt_err_o`, which stays set until reset.
- R11: Pending deliveries leave lowest pin first. A message held with `msg_ready_i` low keeps `msg_valid_o` high and its fields stable.
- R12: After reset every entry is masked with all other bits zero, every count and flag is zero, and no message is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_op_i | input | 2 | Pin operation: 0 none, 1 raise, 2 lower, 3 pulse |
| pin_sel_i | input | 6 | Pin number for the operation |
| ent_wr_i | input | 1 | Entry half-write strobe |
| ent_sel_i | input | 6 | Pin whose entry is written |
| ent_hi_i | input | 1 | 1 writes bits 63:32, 0 writes bits 31:0 |
| ent_data_i | input | 32 | Write data |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_vec_i | input | 8 | Vector being retired |
| msg_valid_o | output | 1 | Delivery message valid |
| msg_ready_i | input | 1 | Downstream accepts the message |
| msg_vector_o | output | 8 | Message vector |
| msg_delmode_o | output | 3 | Message delivery mode |
| msg_logical_o | output | 1 | Destination is logical |
| msg_level_o | output | 1 | Entry is level-triggered |
| msg_dest_o | output | 8 | Destination |
| tmr_req_o | output | 1 | Trigger-mode recalculation request |
| cnt_err_o | output | 1 | Sticky count underflow flag |

## Verification
Directed sequences first exercise one pin alone. They separate a delivery on the first raise from silence on repeated raises and on lowers, and a pulse at zero count from a pulse on an already-raised pin. They also tell masked from unmasked entries, and separate a write that changes only the mask from one that changes the vector. Three level pins sharing a vector are then retired by one EOI under backpressure, which checks priority order and hold stability. A mismatched vector and a zero count confirm that EOI alone triggers nothing. Seeded random mixes of raise, lower, pulse, half-writes, out-of-range pins and EOIs over a small vector set are compared against a bench model of counts, entries and remote-IRR flags. That model predicts every message and every recalculation pulse.

// File: rtl/ioapic_eng_pkg.sv
package ioapic_eng_pkg;

    localparam int ENT_W    = 64;
    localparam int VEC_LSB  = 0;
    localparam int DLM_LSB  = 8;
    localparam int DSTM_BIT = 11;
    localparam int BUSY_BIT = 12;
    localparam int POL_BIT  = 13;
    localparam int RIRR_BIT = 14;
    localparam int TRIG_BIT = 15;
    localparam int MASK_BIT = 16;
    localparam int DEST_LSB = 56;

    localparam logic [ENT_W-1:0] ENT_RESET  = ENT_W'(1) << MASK_BIT;
    localparam logic [31:0]      LO_RO_BITS = (32'd1 << BUSY_BIT) | (32'd1 << RIRR_BIT);
    localparam logic [ENT_W-1:0] TMR_IGNORE = (ENT_W'(1) << MASK_BIT) | (ENT_W'(1) << POL_BIT);

    typedef enum logic [1:0] {
        PIN_NOP   = 2'd0,
        PIN_RAISE = 2'd1,
        PIN_LOWER = 2'd2,
        PIN_PULSE = 2'd3
    } pin_op_e;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] delmode;
        logic       logical;
        logic       level;
        logic [7:0] dest;
    } deliv_msg_t;

    function automatic deliv_msg_t build_msg(logic [ENT_W-1:0] e);
        deliv_msg_t m;
        m.vector  = e[VEC_LSB +: 8];
        m.delmode = e[DLM_LSB +: 3];
        m.logical = e[DSTM_BIT];
        m.level   = e[TRIG_BIT];
        m.dest    = e[DEST_LSB +: 8];
        return m;
    endfunction

endpackage

// File: rtl/pin_assert_cnt.sv
module pin_assert_cnt #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic first_o,
    output logic pos_next_o,
    output logic underflow_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d       = cnt_q;
        underflow_o = 1'b0;
        unique case ({inc_i, dec_i})
            2'b10: begin
                if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
            end
            2'b01: begin
                if (cnt_q == '0) underflow_o = 1'b1;
                else             cnt_d       = cnt_q - CNT_W'(1);
            end
            default: ;
        endcase
        first_o    = inc_i && (cnt_q == '0);
        pos_next_o = (cnt_d != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: a lone raise below the ceiling adds exactly one
    a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R2: a pulse leaves the count where it was
    a_r2_pulse_neutral: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> $stable(cnt_q));

    // R10: lowering a zero count keeps it at zero
    a_r10_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/lowest_first_arb.sv
module lowest_first_arb #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     gnt_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = |req_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        if (any_o) gnt_o[idx_o] = 1'b1;
    end

endmodule

// File: rtl/ioapic_pin_engine.sv
module ioapic_pin_engine
    import ioapic_eng_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int CNT_W    = 8,
    parameter int SEL_W    = $clog2(NUM_PINS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pin_op_i,
    input  logic [SEL_W-1:0] pin_sel_i,
    input  logic             ent_wr_i,
    input  logic [SEL_W-1:0] ent_sel_i,
    input  logic             ent_hi_i,
    input  logic [31:0]      ent_data_i,
    input  logic             eoi_i,
    input  logic [7:0]       eoi_vec_i,
    output logic             msg_valid_o,
    input  logic             msg_ready_i,
    output logic [7:0]       msg_vector_o,
    output logic [2:0]       msg_delmode_o,
    output logic             msg_logical_o,
    output logic             msg_level_o,
    output logic [7:0]       msg_dest_o,
    output logic             tmr_req_o,
    output logic             cnt_err_o
);

    localparam int PIDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    typedef struct packed {
        logic [NUM_PINS-1:0][ENT_W-1:0] ent;
        logic [NUM_PINS-1:0]            rirr;
        logic [NUM_PINS-1:0]            pend;
        logic                           err;
        logic                           tmr;
        logic                           out_v;
        deliv_msg_t                     msg;
    } eng_st_t;

    eng_st_t st_d, st_q;

    // Attempt a delivery on pin p against the state built so far.
    function automatic eng_st_t try_deliver(eng_st_t s, int unsigned p);
        eng_st_t r;
        r = s;
        if (!r.ent[p][MASK_BIT]) begin
            r.pend[p] = 1'b1;
            if (r.ent[p][TRIG_BIT]) r.rirr[p] = 1'b1;
        end
        return r;
    endfunction

    // ---------------- request decode ----------------
    logic              pin_hit, wr_hit;
    logic [PIDX_W-1:0] pin_idx, wr_idx;
    logic [NUM_PINS-1:0] cnt_inc, cnt_dec, cnt_first, cnt_pos, cnt_under;

    assign pin_hit = (pin_op_i != PIN_NOP) && (pin_sel_i < SEL_W'(NUM_PINS));
    assign wr_hit  = ent_wr_i && (ent_sel_i < SEL_W'(NUM_PINS));
    assign pin_idx = pin_sel_i[PIDX_W-1:0];
    assign wr_idx  = ent_sel_i[PIDX_W-1:0];

    // ---------------- per-pin assertion counters ----------------
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // raise and pulse carry bit 0, lower and pulse carry bit 1
        assign cnt_inc[p] = pin_hit && (pin_idx == PIDX_W'(p)) && pin_op_i[0];
        assign cnt_dec[p] = pin_hit && (pin_idx == PIDX_W'(p)) && pin_op_i[1];

        pin_assert_cnt #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .inc_i       (cnt_inc[p]),
            .dec_i       (cnt_dec[p]),
            .first_o     (cnt_first[p]),
            .pos_next_o  (cnt_pos[p]),
            .underflow_o (cnt_under[p])
        );
    end

    // ---------------- pending arbitration ----------------
    logic [NUM_PINS-1:0] gnt_oh;
    logic [PIDX_W-1:0]   gnt_idx;
    logic                gnt_any;
    logic                load_en;

    lowest_first_arb #(
        .N     (NUM_PINS),
        .IDX_W (PIDX_W)
    ) u_arb (
        .req_i (st_q.pend),
        .gnt_o (gnt_oh),
        .idx_o (gnt_idx),
        .any_o (gnt_any)
    );

    assign load_en = !st_q.out_v || msg_ready_i;

    // ---------------- next-state computation ----------------
    logic [ENT_W-1:0] wr_old, wr_new;

    always_comb begin
        st_d   = st_q;
        wr_old = '0;
        wr_new = '0;

        // output register: take the lowest pending pin when free
        if (load_en) begin
            st_d.out_v = gnt_any;
            if (gnt_any) st_d.msg = build_msg(st_q.ent[gnt_idx]);
            st_d.pend  = st_q.pend & ~gnt_oh;
        end

        // entry write; read-only bits stay zero in storage
        st_d.tmr = 1'b0;
        if (wr_hit) begin
            wr_old = st_q.ent[wr_idx];
            wr_new = wr_old;
            if (ent_hi_i) wr_new[63:32] = ent_data_i;
            else          wr_new[31:0]  = ent_data_i & ~LO_RO_BITS;
            st_d.ent[wr_idx] = wr_new;
            st_d.tmr = |((wr_old ^ wr_new) & ~TMR_IGNORE);
        end

        // first assertion of a pin
        for (int unsigned p = 0; p < NUM_PINS; p++) begin
            if (cnt_first[p]) st_d = try_deliver(st_d, p);
        end

        // delivery check after an entry write
        if (wr_hit && !st_d.ent[wr_idx][MASK_BIT] && !st_d.rirr[wr_idx] && cnt_pos[wr_idx])
            st_d = try_deliver(st_d, 32'(wr_idx));

        // end-of-interrupt retire and re-delivery
        if (eoi_i) begin
            for (int unsigned p = 0; p < NUM_PINS; p++) begin
                if (st_d.rirr[p] && (st_d.ent[p][VEC_LSB +: 8] == eoi_vec_i)) begin
                    st_d.rirr[p] = 1'b0;
                    if (cnt_pos[p]) st_d = try_deliver(st_d, p);
                end
            end
        end

        st_d.err = st_q.err | (|cnt_under);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ent   <= {NUM_PINS{ENT_RESET}};
            st_q.rirr  <= '0;
            st_q.pend  <= '0;
            st_q.err   <= 1'b0;
            st_q.tmr   <= 1'b0;
            st_q.out_v <= 1'b0;
            st_q.msg   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msg_valid_o   = st_q.out_v;
    assign msg_vector_o  = st_q.msg.vector;
    assign msg_delmode_o = st_q.msg.delmode;
    assign msg_logical_o = st_q.msg.logical;
    assign msg_level_o   = st_q.msg.level;
    assign msg_dest_o    = st_q.msg.dest;
    assign tmr_req_o     = st_q.tmr;
    assign cnt_err_o     = st_q.err;

    // ---------------- assertions ----------------
    // R11: a stalled message stays valid and unchanged
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out_v && !msg_ready_i) |=> (st_q.out_v && $stable(st_q.msg)));

    // R11: nothing below the granted pin is still pending
    a_r11_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && gnt_any) |-> ((st_q.pend & (gnt_oh - NUM_PINS'(1))) == '0));

    // R10: the underflow flag never drops outside reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    // R8: no recalculation request without an in-range write
    a_r8_tmr_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> !tmr_req_o);

endmodule

// File: tb/ioapic_pin_engine_tb.sv
`timescale 1ns/1ps
module ioapic_pin_engine_tb;

    localparam int NP    = 32;
    localparam int SEL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       pin_op = 2'd0;
    logic [SEL_W-1:0] pin_sel = '0;
    logic             ent_wr = 1'b0;
    logic [SEL_W-1:0] ent_sel = '0;
    logic             ent_hi = 1'b0;
    logic [31:0]      ent_data = '0;
    logic             eoi = 1'b0;
    logic [7:0]       eoi_vec = '0;
    logic             ready = 1'b1;
    logic             msg_valid;
    logic [7:0]       msg_vector;
    logic [2:0]       msg_delmode;
    logic             msg_logical, msg_level;
    logic [7:0]       msg_dest;
    logic             tmr_req, cnt_err;

    always #2.5 clk = ~clk;

    ioapic_pin_engine u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_op_i      (pin_op),
        .pin_sel_i     (pin_sel),
        .ent_wr_i      (ent_wr),
        .ent_sel_i     (ent_sel),
        .ent_hi_i      (ent_hi),
        .ent_data_i    (ent_data),
        .eoi_i         (eoi),
        .eoi_vec_i     (eoi_vec),
        .msg_valid_o   (msg_valid),
        .msg_ready_i   (ready),
        .msg_vector_o  (msg_vector),
        .msg_delmode_o (msg_delmode),
        .msg_logical_o (msg_logical),
        .msg_level_o   (msg_level),
        .msg_dest_o    (msg_dest),
        .tmr_req_o     (tmr_req),
        .cnt_err_o     (cnt_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model
    int unsigned mcnt [NP];
    logic [63:0] ment [NP];
    bit          mrirr[NP];
    bit          merr;
    logic [20:0] exp_q[$];
    logic [20:0] got_q[$];

    function automatic logic [20:0] pack_ent(logic [63:0] e);
        return {e[7:0], e[10:8], e[11], e[15], e[63:56]};
    endfunction

    function automatic logic [20:0] port_msg();
        return {msg_vector, msg_delmode, msg_logical, msg_level, msg_dest};
    endfunction

    function automatic void m_attempt(int p);
        if (!ment[p][16]) begin
            exp_q.push_back(pack_ent(ment[p]));
            if (ment[p][15]) mrirr[p] = 1'b1;
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n && msg_valid && ready) got_q.push_back(port_msg());
    end

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_pin(int p, logic [1:0] op);
        pin_op  = op;
        pin_sel = SEL_W'(p);
        @(posedge clk);
        @(negedge clk);
        pin_op = 2'd0;
        if (p < NP) begin
            case (op)
                2'd1: begin
                    if (mcnt[p] == 0) m_attempt(p);
                    if (mcnt[p] < 255) mcnt[p]++;
                end
                2'd2: begin
                    if (mcnt[p] == 0) merr = 1'b1;
                    else mcnt[p]--;
                end
                2'd3: if (mcnt[p] == 0) m_attempt(p);
                default: ;
            endcase
        end
    endtask

    task automatic do_write(int p, bit hi, logic [31:0] data);
        logic [63:0] old_e, new_e;
        bit exp_tmr;
        ent_wr   = 1'b1;
        ent_sel  = SEL_W'(p);
        ent_hi   = hi;
        ent_data = data;
        @(posedge clk);
        @(negedge clk);
        ent_wr  = 1'b0;
        exp_tmr = 1'b0;
        if (p < NP) begin
            old_e = ment[p];
            new_e = old_e;
            if (hi) new_e[63:32] = data;
            else    new_e[31:0]  = data & ~32'h0000_5000;
            exp_tmr = |((old_e ^ new_e) & ~64'h0000_0000_0001_2000);
            ment[p] = new_e;
            if (!new_e[16] && !mrirr[p] && mcnt[p] > 0) m_attempt(p);
        end
        check(tmr_req == exp_tmr, "R8", "tmr_req", 64'(tmr_req), 64'(exp_tmr));
    endtask

    task automatic do_eoi(logic [7:0] v);
        eoi     = 1'b1;
        eoi_vec = v;
        @(posedge clk);
        @(negedge clk);
        eoi = 1'b0;
        for (int p = 0; p < NP; p++) begin
            if (mrirr[p] && ment[p][7:0] == v) begin
                mrirr[p] = 1'b0;
                if (mcnt[p] > 0) m_attempt(p);
            end
        end
    endtask

    task automatic settle(string tag);
        bit ok;
        int first_bad;
        repeat (NP + 8) @(negedge clk);
        check(got_q.size() == exp_q.size(), tag, "message count",
              64'(got_q.size()), 64'(exp_q.size()));
        ok = 1'b1;
        first_bad = 0;
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
            if (ok && got_q[i] != exp_q[i]) begin
                ok = 1'b0;
                first_bad = i;
            end
        end
        if (!ok) check(1'b0, tag, "message content",
                       64'(got_q[first_bad]), 64'(exp_q[first_bad]));
        else     check(1'b1, tag, "message content", 0, 0);
        check(cnt_err == merr, "R10", "cnt_err", 64'(cnt_err), 64'(merr));
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic set_ready(bit v);
        @(posedge clk);
        #1 ready = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < NP; p++) begin
            mcnt[p]  = 0;
            ment[p]  = 64'h0000_0000_0001_0000;
            mrirr[p] = 1'b0;
        end
        merr = 1'b0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: idle after reset
        check(msg_valid == 1'b0, "R12", "msg_valid", 64'(msg_valid), 0);
        check(tmr_req == 1'b0, "R12", "tmr_req", 64'(tmr_req), 0);
        check(cnt_err == 1'b0, "R12", "cnt_err", 64'(cnt_err), 0);
        // R12: entries start masked, so a raise is silent
        do_pin(0, 2'd1); settle("R12");
        do_pin(0, 2'd2); settle("R12");

        // R1: edge pin 3, vector 41, destination 05
        do_write(3, 1'b1, 32'h0500_0000); settle("R8");
        do_write(3, 1'b0, 32'h0000_0041); settle("R8");
        do_pin(3, 2'd1); settle("R1");
        do_pin(3, 2'd1); settle("R1");
        do_pin(3, 2'd2); settle("R1");
        do_pin(3, 2'd2); settle("R1");

        // R2: pulse at zero delivers, pulse on a raised pin does not
        do_pin(3, 2'd3); settle("R2");
        do_pin(3, 2'd1); settle("R2");
        do_pin(3, 2'd3); settle("R2");
        do_pin(3, 2'd2); settle("R2");

        // R9: pins beyond the table are ignored, no underflow either
        do_pin(40, 2'd1); settle("R9");
        do_pin(40, 2'd2); settle("R9");
        do_write(45, 1'b0, 32'h0000_0033); settle("R9");

        // R4 and R6: level pin 5, vector 50
        do_write(5, 1'b1, 32'h0900_0000); settle("R4");
        do_write(5, 1'b0, 32'h0000_8050); settle("R4");
        do_pin(5, 2'd1); settle("R4");
        do_write(5, 1'b0, 32'h0000_C050); settle("R4");
        do_eoi(8'h51); settle("R6");
        do_eoi(8'h50); settle("R6");
        do_pin(5, 2'd2);
        do_eoi(8'h50); settle("R6");

        // R3 and R7: masked pin 6, then unmask only
        do_write(6, 1'b0, 32'h0001_8050); settle("R3");
        do_pin(6, 2'd1); settle("R3");
        do_write(6, 1'b0, 32'h0000_8050); settle("R7");

        // R11: three level pins on one vector retired under backpressure
        do_write(7, 1'b0, 32'h0000_8350); settle("R11");
        do_pin(7, 2'd1); settle("R11");
        do_pin(5, 2'd1); settle("R11");
        set_ready(1'b0);
        do_eoi(8'h50);
        repeat (6) @(negedge clk);
        check(msg_valid == 1'b1, "R11", "valid while stalled", 64'(msg_valid), 1);
        check(port_msg() == pack_ent(ment[5]), "R11", "lowest pin first",
              64'(port_msg()), 64'(pack_ent(ment[5])));
        repeat (3) @(negedge clk);
        check(port_msg() == pack_ent(ment[5]), "R11", "held message",
              64'(port_msg()), 64'(pack_ent(ment[5])));
        set_ready(1'b1);
        settle("R11");

        // R5: field positions
        do_write(8, 1'b1, 32'hA700_0000); settle("R5");
        do_write(8, 1'b0, 32'h0000_0ABC); settle("R5");
        set_ready(1'b0);
        do_pin(8, 2'd1);
        repeat (3) @(negedge clk);
        check(msg_vector == 8'hBC, "R5", "vector", 64'(msg_vector), 64'h BC);
        check(msg_delmode == 3'd2, "R5", "delmode", 64'(msg_delmode), 2);
        check(msg_logical == 1'b1, "R5", "logical", 64'(msg_logical), 1);
        check(msg_level == 1'b0, "R5", "level", 64'(msg_level), 0);
        check(msg_dest == 8'hA7, "R5", "dest", 64'(msg_dest), 64'hA7);
        set_ready(1'b1);
        settle("R5");

        // R10: underflow saturates and sticks
        do_pin(9, 2'd2); settle("R10");
        do_pin(9, 2'd3); settle("R10");

        // seeded random mix
        for (int k = 0; k < 700; k++) begin
            int r;
            int p;
            logic [31:0] dat;
            r = int'($urandom % 10);
            if (r < 4) begin
                p = ($urandom % 10 == 0) ? int'(32 + $urandom % 32) : int'($urandom % 8);
                do_pin(p, 2'(1 + $urandom % 3));
                settle("R1");
            end else if (r < 7) begin
                p = ($urandom % 20 == 0) ? 33 : int'($urandom % 8);
                if ($urandom % 3 == 0) begin
                    dat = $urandom;
                    do_write(p, 1'b1, dat);
                end else begin
                    dat = $urandom;
                    dat[7:0] = 8'h20 + 8'($urandom % 4);
                    dat[16]  = ($urandom % 3 == 0);
                    do_write(p, 1'b0, dat);
                end
                settle("R7");
            end else begin
                do_eoi(8'h20 + 8'($urandom % 4));
                settle("R6");
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule